// File: doc/BRIEF.md
# Bit-Swapping Pseudo-Random Pattern Generator

This block produces two pseudo-random test-pattern streams from one state register. A linear-feedback shift register of parameterised width (12 bits by default) advances under an enable, and a bank of 2:1 multiplexers on its outputs forms a second pattern. When the register's least significant bit is 0, the multiplexers exchange neighbouring bit pairs above bit 1. When that bit is 1, the register value passes through unchanged. The swap only moves bits, so both streams carry the same number of ones. The second stream lowers transition activity in the applied patterns and costs no extra flip-flops.

A seed port loads a new starting state, so the same hardware can walk several sequences. A parameter picks the feedback structure: external XOR feedback into bit 0, or internal XOR gates between the stages. Both structures use the same characteristic polynomial, x^12 + x^9 + x^7 + x^5 + x^2 + 1 for the default tap mask. A zero seed would lock the register, so a zero seed is replaced by the reset seed.

Top module: `bslfsr_gen`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first enabled or load edge, `lfsr_out` equals the reset seed (default 12'hACE). `pattern_out` shows that state through the swap rule.
- R2: On a clock edge with `seed_load` high and `seed_in` nonzero, `lfsr_out` takes `seed_in`. A load takes priority over `step_en`.
- R3: On a clock edge with `seed_load` high and `seed_in` equal to zero, `lfsr_out` takes the reset seed instead.
- R4: With the external-feedback variant (default), an edge with `step_en` high and no load gives next = {s[10:0], s[11]^s[8]^s[6]^s[4]^s[1]}.
- R5: With the internal-feedback variant, an edge with `step_en` high and no load gives next = {s[10:0],1'b0}, XORed with 12'h2A5 when s[11] is 1.
- R6: An edge with neither `seed_load` nor `step_en` leaves `lfsr_out` unchanged.
- R7: `lfsr_out` is never all zeros.
- R8: When `lfsr_out[0]` is 0, `pattern_out` exchanges each pair of bits (2k+1, 2k) for k = 1..5, in the same cycle.
- R9: `pattern_out[1:0]` always equals `lfsr_out[1:0]`.
- R10: When `lfsr_out[0]` is 1, `pattern_out` equals `lfsr_out`.
- R11: `pattern_out` always has the same number of ones as `lfsr_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset to the reset seed |
| seed_load | input | 1 | Load `seed_in` (or the reset seed if zero) at the next edge |
| seed_in | input | 12 | Seed value |
| step_en | input | 1 | Advance the register one step |
| pattern_out | output | 12 | Pair-swapped pattern stream |
| lfsr_out | output | 12 | Register state, unswapped |

## Verification
A wrong next-state bit in the register shows on `lfsr_out` one edge after the step that produced it. It also changes every later state, so one bad step spoils the rest of the sequence until the next seed load. A wrong multiplexer select or pair wiring shows on `pattern_out` in the same cycle, but only for states whose bit 0 takes the faulty value. Random stimulus must therefore visit both values of bit 0 often. Ones-count and low-bit comparisons catch wiring that drops or duplicates a bit even where the swap direction happens to agree.

// File: rtl/bslfsr_pkg.sv
package bslfsr_pkg;

   // Feedback placement of the shift register.
   typedef enum logic {
      FB_EXTERNAL = 1'b0,   // XOR tree outside the chain, result into bit 0
      FB_INTERNAL = 1'b1    // XOR gates between stages, MSB fans back
   } fb_style_e;

   localparam int unsigned DEF_WIDTH = 12;
   // External taps: positions (exponent - 1) of x^12+x^9+x^7+x^5+x^2+1.
   localparam logic [DEF_WIDTH-1:0] DEF_TAPS = 12'h952;
   localparam logic [DEF_WIDTH-1:0] DEF_SEED = 12'hACE;

endpackage

// File: rtl/bslfsr_core.sv
module bslfsr_core
   import bslfsr_pkg::*;
#(
   parameter int unsigned     W          = DEF_WIDTH,
   parameter fb_style_e       FB_STYLE   = FB_EXTERNAL,
   parameter logic [W-1:0]    TAP_MASK   = DEF_TAPS,
   parameter logic [W-1:0]    RESET_SEED = DEF_SEED
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         seed_load,
   input  logic [W-1:0] seed_in,
   input  logic         step_en,
   output logic [W-1:0] state_q
);

   // Internal-feedback mask: same polynomial, terms shifted up one place,
   // the x^W term dropped and the constant term placed at bit 0.
   localparam logic [W:0]   TAPS_SHIFTED = {TAP_MASK, 1'b0};
   localparam logic [W-1:0] GAL_MASK     = TAPS_SHIFTED[W-1:0] | {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] step_val;
   logic [W-1:0] load_val;
   logic [W-1:0] state_d;

   generate
      if (FB_STYLE == FB_EXTERNAL) begin : g_ext
         logic fb_bit;
         assign fb_bit   = ^(state_q & TAP_MASK);
         assign step_val = {state_q[W-2:0], fb_bit};
      end else begin : g_int
         assign step_val = {state_q[W-2:0], 1'b0} ^ ({W{state_q[W-1]}} & GAL_MASK);
      end
   endgenerate

   // A zero seed would freeze the register; fall back to the reset seed.
   assign load_val = (seed_in == '0) ? RESET_SEED : seed_in;

   always_comb begin
      state_d = state_q;
      if (seed_load)    state_d = load_val;
      else if (step_en) state_d = step_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= RESET_SEED;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/bslfsr_swap.sv
module bslfsr_swap #(
   parameter int unsigned W = 12
) (
   input  logic [W-1:0] raw_in,
   output logic [W-1:0] swp_out
);

   localparam int unsigned NPAIRS = W / 2;

   logic do_swap;
   assign do_swap = ~raw_in[0];

   // Pair 0 (bits 1 and 0) is never swapped; it carries the select bit.
   assign swp_out[1:0] = raw_in[1:0];

   generate
      for (genvar k = 1; k < NPAIRS; k++) begin : g_pair
         assign swp_out[2*k+1] = do_swap ? raw_in[2*k]   : raw_in[2*k+1];
         assign swp_out[2*k]   = do_swap ? raw_in[2*k+1] : raw_in[2*k];
      end
   endgenerate

endmodule

// File: rtl/bslfsr_gen.sv
module bslfsr_gen
   import bslfsr_pkg::*;
#(
   parameter int unsigned     W          = DEF_WIDTH,
   parameter fb_style_e       FB_STYLE   = FB_EXTERNAL,
   parameter logic [W-1:0]    TAP_MASK   = DEF_TAPS,
   parameter logic [W-1:0]    RESET_SEED = DEF_SEED
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         seed_load,
   input  logic [W-1:0] seed_in,
   input  logic         step_en,
   output logic [W-1:0] pattern_out,
   output logic [W-1:0] lfsr_out
);

   // Elaboration-time parameter checks.
   generate
      if (W < 4)              begin : g_bad_w    $error("bslfsr_gen: W must be at least 4");        end
      if ((W % 2) != 0)       begin : g_odd_w    $error("bslfsr_gen: W must be even");              end
      if (!TAP_MASK[W-1])     begin : g_bad_taps $error("bslfsr_gen: TAP_MASK MSB must be set");    end
      if (RESET_SEED == '0)   begin : g_bad_seed $error("bslfsr_gen: RESET_SEED must be nonzero");  end
   endgenerate

   logic [W-1:0] state_q;

   bslfsr_core #(
      .W          (W),
      .FB_STYLE   (FB_STYLE),
      .TAP_MASK   (TAP_MASK),
      .RESET_SEED (RESET_SEED)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .seed_load (seed_load),
      .seed_in   (seed_in),
      .step_en   (step_en),
      .state_q   (state_q)
   );

   bslfsr_swap #(
      .W (W)
   ) u_swap (
      .raw_in  (state_q),
      .swp_out (pattern_out)
   );

   assign lfsr_out = state_q;

endmodule

// File: rtl/bslfsr_chk.sv
module bslfsr_chk
   import bslfsr_pkg::*;
#(
   parameter int unsigned  W          = DEF_WIDTH,
   parameter fb_style_e    FB_STYLE   = FB_EXTERNAL,
   parameter logic [W-1:0] RESET_SEED = DEF_SEED
) (
   input logic         clk,
   input logic         rst_n,
   input logic         seed_load,
   input logic [W-1:0] seed_in,
   input logic         step_en,
   input logic [W-1:0] pattern_out,
   input logic [W-1:0] lfsr_out
);

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (seed_load && seed_in != '0) |=> lfsr_out == $past(seed_in));

   assert_zero_seed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (seed_load && seed_in == '0) |=> lfsr_out == RESET_SEED);

   generate
      if (FB_STYLE == FB_EXTERNAL) begin : g_ext
         assert_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (step_en && !seed_load) |=> lfsr_out[W-1:1] == $past(lfsr_out[W-2:0]));
      end else begin : g_int
         assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (step_en && !seed_load) |=> lfsr_out[0] == $past(lfsr_out[W-1]));
      end
   endgenerate

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_en && !seed_load) |=> $stable(lfsr_out));

   assert_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_out != '0);

   generate
      for (genvar k = 1; k < W/2; k++) begin : g_pair
         assert_pair_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !lfsr_out[0] |-> (pattern_out[2*k+1] == lfsr_out[2*k] &&
                              pattern_out[2*k]   == lfsr_out[2*k+1]));
      end
   endgenerate

   assert_low_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pattern_out[1:0] == lfsr_out[1:0]);

   assert_no_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_out[0] |-> pattern_out == lfsr_out);

   assert_ones_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pattern_out) == $countones(lfsr_out));

endmodule

bind bslfsr_gen bslfsr_chk #(
   .W          (W),
   .FB_STYLE   (FB_STYLE),
   .RESET_SEED (RESET_SEED)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .seed_load   (seed_load),
   .seed_in     (seed_in),
   .step_en     (step_en),
   .pattern_out (pattern_out),
   .lfsr_out    (lfsr_out)
);

// File: tb/tb_bslfsr_gen.sv
`timescale 1ns/1ps
module tb_bslfsr_gen;
   import bslfsr_pkg::*;

   localparam logic [11:0] SEED0 = 12'hACE;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        seed_load = 1'b0;
   logic [11:0] seed_in = '0;
   logic        step_en = 1'b0;
   logic [11:0] pat_e, st_e, pat_i, st_i;

   int n_cmp = 0;
   int n_bad = 0;
   logic [11:0] m_ext, m_int;

   always #2.5 clk = ~clk;   // 200 MHz

   bslfsr_gen #(.FB_STYLE(FB_EXTERNAL)) dut (
      .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_in(seed_in),
      .step_en(step_en), .pattern_out(pat_e), .lfsr_out(st_e));

   bslfsr_gen #(.FB_STYLE(FB_INTERNAL)) dut_int (
      .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_in(seed_in),
      .step_en(step_en), .pattern_out(pat_i), .lfsr_out(st_i));

   function automatic logic [11:0] ext_next(logic [11:0] s);
      return {s[10:0], s[11] ^ s[8] ^ s[6] ^ s[4] ^ s[1]};
   endfunction

   function automatic logic [11:0] int_next(logic [11:0] s);
      logic [11:0] t = {s[10:0], 1'b0};
      if (s[11]) t = t ^ 12'h2A5;
      return t;
   endfunction

   function automatic logic [11:0] swap_ref(logic [11:0] s);
      logic [11:0] r = s;
      if (!s[0])
         for (int k = 1; k < 6; k++) begin
            r[2*k]   = s[2*k+1];
            r[2*k+1] = s[2*k];
         end
      return r;
   endfunction

   function automatic int ones(logic [11:0] v);
      int c = 0;
      for (int i = 0; i < 12; i++) c += int'(v[i]);
      return c;
   endfunction

   task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_outputs(string st_req, string st_req_i);
      chk(st_req,   st_e, m_ext);
      chk(st_req_i, st_i, m_int);
      chk(m_ext[0] ? "R10" : "R8", pat_e, swap_ref(m_ext));
      chk(m_int[0] ? "R10" : "R8", pat_i, swap_ref(m_int));
      chk("R9",  {10'd0, pat_e[1:0]}, {10'd0, st_e[1:0]});
      chk("R11", 12'(ones(pat_e)), 12'(ones(st_e)));
      chk("R11", 12'(ones(pat_i)), 12'(ones(st_i)));
      n_cmp++;
      if (st_e == '0 || st_i == '0) begin
         n_bad++;
         $display("FAIL R7 actual=%h/%h expected=nonzero", st_e, st_i);
      end
   endtask

   // Called at a falling edge: drive, advance models across the next
   // rising edge, then compare at the following falling edge.
   task automatic cycle(logic ld, logic [11:0] sd, logic en);
      string r_e, r_i;
      seed_load = ld; seed_in = sd; step_en = en;
      if (ld) begin
         m_ext = (sd == '0) ? SEED0 : sd;
         m_int = m_ext;
         r_e = (sd == '0) ? "R3" : "R2";
         r_i = r_e;
      end else if (en) begin
         m_ext = ext_next(m_ext); m_int = int_next(m_int);
         r_e = "R4"; r_i = "R5";
      end else begin
         r_e = "R6"; r_i = "R6";
      end
      @(negedge clk);
      chk_outputs(r_e, r_i);
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
   end

   initial begin
      void'($urandom(32'd1357));
      m_ext = SEED0; m_int = SEED0;
      repeat (3) @(negedge clk);
      chk_outputs("R1", "R1");          // reset state, in reset
      rst_n = 1'b1;
      @(negedge clk);
      chk_outputs("R1", "R1");          // still seed after first idle edge

      cycle(1'b1, 12'hAAA, 1'b1);       // R2 load beats enable; R8 -> 556
      chk("R8", pat_e, 12'h556);
      cycle(1'b0, 12'h000, 1'b0);       // R6 holds
      cycle(1'b0, 12'h123, 1'b0);
      cycle(1'b1, 12'h000, 1'b0);       // R3 zero seed
      cycle(1'b1, 12'h555, 1'b0);       // R10 bit0 = 1
      chk("R10", pat_e, 12'h555);
      cycle(1'b1, 12'h001, 1'b0);
      for (int i = 0; i < 30; i++) cycle(1'b0, 12'h0, 1'b1);
      cycle(1'b1, 12'h800, 1'b1);
      for (int i = 0; i < 30; i++) cycle(1'b0, 12'h0, 1'b1);
      cycle(1'b1, 12'hFFF, 1'b0);

      for (int i = 0; i < 3000; i++) begin
         int unsigned r = $urandom % 100;
         logic [11:0] sd = (r < 3) ? 12'h000 : 12'($urandom);
         cycle(r < 10, sd, ($urandom % 4) != 0);
      end
      summary();
   end

endmodule